// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block generates the two port-to-port interrupt flags that go with a shared dual-port memory. It watches the access strobes of the left and right ports. It reacts only to accesses that land on the two uppermost word addresses of the memory.

The all-ones address is the right port's mailbox. The address one below it is the left port's mailbox. When one port writes the other port's mailbox, the owner of that mailbox gets an interrupt. The owner clears the interrupt by reading its own mailbox. The message data stays in the shared RAM and does not pass through this block.

Each port also has a busy input from the contention arbiter. While a port's busy is active, that port cannot raise the other side's interrupt and cannot clear its own. The interrupt outputs are active low. They change on the clock edge that follows the access.

Top module: `mbx_irq_top`

## Requirements
- R1: During and after reset, with no mailbox access, both `lt_irq_n` and `rt_irq_n` are 1 (inactive).
- R2: A left-port write sets the right interrupt: `rt_irq_n` reads 0 after the next clock edge. The write is `lt_en`=1, `lt_we`=1, `lt_busy`=0, and `lt_addr` all ones (the right mailbox, 0x7FFF with the default 15-bit address).
- R3: A right-port write sets the left interrupt: `lt_irq_n` reads 0 after the next clock edge. The write is `rt_en`=1, `rt_we`=1, `rt_busy`=0, and `rt_addr` equal to all ones minus one (the left mailbox, 0x7FFE by default).
- R4: A port that reads its own mailbox clears its own interrupt to 1 after the next clock edge. The read is `en`=1, `oe`=1, `we`=0 and `busy`=0 on that port.
- R5: A port that reads the other port's mailbox changes neither interrupt.
- R6: While a port's `busy` is 1, its write to the other port's mailbox does not set that interrupt.
- R7: While a port's `busy` is 1, its read of its own mailbox does not clear its interrupt.
- R8: If the same flag is set and cleared in the same cycle, it ends up set (output 0).
- R9: The following leave both interrupts unchanged:
  - a read with `oe`=0 or `en`=0;
  - a write to any address other than the peer's mailbox;
  - a port writing its own mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lt_en | input | 1 | Left port access enable, active high |
| lt_we | input | 1 | Left port write strobe (1 = write, 0 = read) |
| lt_oe | input | 1 | Left port output enable, active high |
| lt_addr | input | AW | Left port word address |
| lt_busy | input | 1 | Left port busy from the arbiter, active high |
| lt_irq_n | output | 1 | Interrupt to the left port, active low |
| rt_en | input | 1 | Right port access enable, active high |
| rt_we | input | 1 | Right port write strobe (1 = write, 0 = read) |
| rt_oe | input | 1 | Right port output enable, active high |
| rt_addr | input | AW | Right port word address |
| rt_busy | input | 1 | Right port busy from the arbiter, active high |
| rt_irq_n | output | 1 | Interrupt to the right port, active low |

## Verification
The bench targets the following corner cases:
- **Mailboxes swapped.** A port reads the peer's mailbox. A design with the two mailboxes swapped would drop the wrong interrupt.
- **Busy ignored.** A busy port attempts a set, and separately a clear. A design that ignored busy would change the flag anyway.
- **Set and clear together.** Both hit the same flag in one cycle. A design with clear priority would lose a fresh message.
- **Incomplete read qualifier.** The owner reads with output enable low. A design that did not check the full read qualifier would clear on that access.
- **Write to own mailbox.** A port writes its own mailbox. A design that decoded the address without checking which port it came from would raise a flag here.

Address-adjacent writes one word below each mailbox confirm that the decode is exact.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Events decoded from one port's strobes in one cycle.
  typedef struct packed {
    logic set_peer;  // write that raises the other port's flag
    logic clr_own;   // read that clears this port's flag
  } mbx_evt_t;

  // Mailbox word address: all ones for the right box, one lower for the left.
  function automatic logic [63:0] mbox_addr(input int aw, input bit right_box);
    logic [63:0] top;
    top = (64'd1 << aw) - 64'd1;
    return right_box ? top : top - 64'd1;
  endfunction

  // Next flag state: a set wins over a clear in the same cycle.
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
  import mbx_pkg::*;
#(
  parameter int AW = 15,
  parameter bit OWN_RIGHT = 1'b0
) (
  input  logic          en,
  input  logic          we,
  input  logic          oe,
  input  logic          busy,
  input  logic [AW-1:0] addr,
  output mbx_evt_t      evt
);

  localparam logic [63:0] OWN_BOX  = mbox_addr(AW, OWN_RIGHT);
  localparam logic [63:0] PEER_BOX = mbox_addr(AW, !OWN_RIGHT);

  logic [63:0] addr_x;
  logic hit_own, hit_peer, is_wr, is_rd;

  assign addr_x   = {{(64-AW){1'b0}}, addr};
  assign hit_own  = (addr_x == OWN_BOX);
  assign hit_peer = (addr_x == PEER_BOX);
  assign is_wr    = en & we & ~busy;
  assign is_rd    = en & ~we & oe & ~busy;

  assign evt.set_peer = is_wr & hit_peer;
  assign evt.clr_own  = is_rd & hit_own;

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag
  import mbx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);

  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= flag_next(pend_q, set, clr);
  end

  assign irq_n = ~pend_q;

endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
  import mbx_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lt_en,
  input  logic          lt_we,
  input  logic          lt_oe,
  input  logic [AW-1:0] lt_addr,
  input  logic          lt_busy,
  output logic          lt_irq_n,
  input  logic          rt_en,
  input  logic          rt_we,
  input  logic          rt_oe,
  input  logic [AW-1:0] rt_addr,
  input  logic          rt_busy,
  output logic          rt_irq_n
);

  localparam int NP = 2;  // index 0 = left, 1 = right

  logic [NP-1:0]   p_en, p_we, p_oe, p_busy, p_irq_n;
  logic [AW-1:0]   p_addr [NP];
  mbx_evt_t        p_evt  [NP];

  // Named events, also observed by the checker.
  logic [NP-1:0]   set_flag, clr_flag;

  assign p_en   = {rt_en,   lt_en};
  assign p_we   = {rt_we,   lt_we};
  assign p_oe   = {rt_oe,   lt_oe};
  assign p_busy = {rt_busy, lt_busy};
  assign p_addr[0] = lt_addr;
  assign p_addr[1] = rt_addr;

  for (genvar g = 0; g < NP; g++) begin : g_port
    mbx_port_dec #(.AW(AW), .OWN_RIGHT(g == 1)) u_dec (
      .en   (p_en[g]),
      .we   (p_we[g]),
      .oe   (p_oe[g]),
      .busy (p_busy[g]),
      .addr (p_addr[g]),
      .evt  (p_evt[g])
    );

    // A flag is set by the opposite port and cleared by its owner.
    assign set_flag[g] = p_evt[NP-1-g].set_peer;
    assign clr_flag[g] = p_evt[g].clr_own;

    mbx_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (set_flag[g]),
      .clr   (clr_flag[g]),
      .irq_n (p_irq_n[g])
    );
  end

  assign lt_irq_n = p_irq_n[0];
  assign rt_irq_n = p_irq_n[1];

endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lt_en,
  input logic          lt_we,
  input logic          lt_oe,
  input logic [AW-1:0] lt_addr,
  input logic          lt_busy,
  input logic          lt_irq_n,
  input logic          rt_en,
  input logic          rt_we,
  input logic          rt_oe,
  input logic [AW-1:0] rt_addr,
  input logic          rt_busy,
  input logic          rt_irq_n,
  input logic [1:0]    set_flag,
  input logic [1:0]    clr_flag
);

  localparam logic [AW-1:0] RBOX = {AW{1'b1}};
  localparam logic [AW-1:0] LBOX = {{(AW-1){1'b1}}, 1'b0};

  logic lt_rd_own, rt_rd_own;
  assign lt_rd_own = lt_en && !lt_we && lt_oe && (lt_addr == LBOX);
  assign rt_rd_own = rt_en && !rt_we && rt_oe && (rt_addr == RBOX);

  a_r2_left_write_sets_right: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_en && lt_we && !lt_busy && lt_addr == RBOX) |=> !rt_irq_n);

  a_r3_right_write_sets_left: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_en && rt_we && !rt_busy && rt_addr == LBOX) |=> !lt_irq_n);

  a_r4_owner_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_rd_own && !rt_busy && !set_flag[1]) |=> rt_irq_n);

  a_r6_busy_blocks_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_irq_n && lt_busy) |=> rt_irq_n);

  a_r7_busy_blocks_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!lt_irq_n && lt_busy) |=> !lt_irq_n);

  a_r5_only_owner_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!lt_irq_n && !lt_rd_own) |=> !lt_irq_n);

  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flag[0] && clr_flag[0]) |=> !lt_irq_n);

endmodule

bind mbx_irq_top mbx_irq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .lt_en(lt_en), .lt_we(lt_we), .lt_oe(lt_oe), .lt_addr(lt_addr),
  .lt_busy(lt_busy), .lt_irq_n(lt_irq_n),
  .rt_en(rt_en), .rt_we(rt_we), .rt_oe(rt_oe), .rt_addr(rt_addr),
  .rt_busy(rt_busy), .rt_irq_n(rt_irq_n),
  .set_flag(set_flag), .clr_flag(clr_flag)
);

// File: tb/mbx_irq_top_test.sv
`timescale 1ns/1ps
module mbx_irq_top_test;

  localparam int AW = 15;
  localparam logic [AW-1:0] RBOX = 15'h7FFF;
  localparam logic [AW-1:0] LBOX = 15'h7FFE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lt_en = 0, lt_we = 0, lt_oe = 0, lt_busy = 0;
  logic rt_en = 0, rt_we = 0, rt_oe = 0, rt_busy = 0;
  logic [AW-1:0] lt_addr = '0, rt_addr = '0;
  logic lt_irq_n, rt_irq_n;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 0;

  // Reference state: 1 = interrupt pending.
  bit m_l = 0, m_r = 0;

  always #5 clk = ~clk;

  mbx_irq_top #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .lt_en(lt_en), .lt_we(lt_we), .lt_oe(lt_oe), .lt_addr(lt_addr),
    .lt_busy(lt_busy), .lt_irq_n(lt_irq_n),
    .rt_en(rt_en), .rt_we(rt_we), .rt_oe(rt_oe), .rt_addr(rt_addr),
    .rt_busy(rt_busy), .rt_irq_n(rt_irq_n)
  );

  task automatic compare(input string tag);
    vectors++;
    if (lt_irq_n !== !m_l) begin
      errors++;
      $display("FAIL %s: lt_irq_n=%b expected %b", tag, lt_irq_n, !m_l);
    end
    if (rt_irq_n !== !m_r) begin
      errors++;
      $display("FAIL %s: rt_irq_n=%b expected %b", tag, rt_irq_n, !m_r);
    end
  endtask

  // One bus cycle: drive at negedge, model at posedge, compare at next negedge.
  task automatic op(input string tag,
                    input bit le, input bit lw, input bit lo, input bit lb,
                    input logic [AW-1:0] la,
                    input bit re, input bit rw, input bit ro, input bit rb,
                    input logic [AW-1:0] ra);
    bit ls, lc, rs, rc;
    lt_en = le; lt_we = lw; lt_oe = lo; lt_busy = lb; lt_addr = la;
    rt_en = re; rt_we = rw; rt_oe = ro; rt_busy = rb; rt_addr = ra;
    @(posedge clk);
    ls = re && rw && !rb && (ra == LBOX);
    lc = le && !lw && lo && !lb && (la == LBOX);
    rs = le && lw && !lb && (la == RBOX);
    rc = re && !rw && ro && !rb && (ra == RBOX);
    if (ls) m_l = 1; else if (lc) m_l = 0;
    if (rs) m_r = 1; else if (rc) m_r = 0;
    @(negedge clk);
    compare(tag);
  endtask

  localparam logic [AW-1:0] Z = '0;

  initial begin
    @(negedge clk); @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    op("R1 idle", 0,0,0,0,Z, 0,0,0,0,Z);
    // R2: left writes right mailbox
    op("R2 set right", 1,1,0,0,RBOX, 0,0,0,0,Z);
    // R5: left reads right's mailbox, no clear
    op("R5 peer read", 1,0,1,0,RBOX, 0,0,0,0,Z);
    // R7: right busy read of own box
    op("R7 busy read", 0,0,0,0,Z, 1,0,1,1,RBOX);
    // R9: oe low read, en low read
    op("R9 oe low", 0,0,0,0,Z, 1,0,0,0,RBOX);
    op("R9 en low", 0,0,0,0,Z, 0,0,1,0,RBOX);
    // R4: right reads own box
    op("R4 clear right", 0,0,0,0,Z, 1,0,1,0,RBOX);
    // R6: busy left write
    op("R6 busy write", 1,1,0,1,RBOX, 0,0,0,0,Z);
    // R9: write below mailbox, own mailbox write
    op("R9 near addr", 1,1,0,0,15'h7FFD, 0,0,0,0,Z);
    op("R9 own box wr", 1,1,0,0,LBOX, 1,1,0,0,RBOX);
    // R3: right writes left box
    op("R3 set left", 0,0,0,0,Z, 1,1,0,0,LBOX);
    op("R5 right reads left box", 0,0,0,0,Z, 1,0,1,0,LBOX);
    op("R7 busy left read", 1,0,1,1,LBOX, 0,0,0,0,Z);
    // R8: set and clear of left together
    op("R8 set wins left", 1,0,1,0,LBOX, 1,1,0,0,LBOX);
    op("R4 clear left", 1,0,1,0,LBOX, 0,0,0,0,Z);
    // R8 on right flag
    op("R8 set wins right", 1,1,0,0,RBOX, 1,0,1,0,RBOX);
    op("R4 clear right again", 0,0,0,0,Z, 1,0,1,0,RBOX);
    // Mixed traffic near the mailboxes
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a1, a2;
      a1 = 15'h7FFC | AW'($urandom_range(0, 3));
      a2 = 15'h7FFC | AW'($urandom_range(0, 3));
      op("R2 R3 R4 R6 R7 mixed",
         1'($urandom), 1'($urandom), 1'($urandom), ($urandom_range(0,3) == 0), a1,
         1'($urandom), 1'($urandom), 1'($urandom), ($urandom_range(0,3) == 0), a2);
    end
    // Reset mid-run
    rst_n = 1'b0; m_l = 0; m_r = 0;
    @(negedge clk);
    compare("R1 re-reset");
    finish_run();
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      finish_run();
    end
  end

endmodule